// File: doc/BRIEF.md
# I2S Stereo Frame Serializer

This block is the serial data path of an I2S port that runs as clock master. It produces the bit clock and the word-select line itself, from a half-bit timing strobe supplied by an external divider. Each frame carries a left and a right channel, and each channel occupies a 32-bit slot. The transmit side takes one 16-bit sample per slot from a transmit FIFO and shifts it out MSB-first. The rest of the slot is filled with zeros. The receive side keeps the first 16 bits of each slot on the serial input and pushes them as one sample into a receive FIFO.

Transmit and receive each have their own enable. The frame sequencer reads both enables once per frame, at the moment word-select falls for the next left channel. A frame that has started therefore always completes, and an idle indication follows the last frame. Two polarity controls invert the bit-clock pin and the word-select pin independently. When the transmit FIFO is empty at a fetch, a strobe flags an underrun. When the receive FIFO is full at a push, a strobe flags an overrun.

The sequencer has four states:
- IDLE: no frame is running.
- LEAD: the single word-select-low bit that precedes the first frame.
- LEFT: the left slot, 32 bits.
- RIGHT: the right slot, 32 bits.

Its transitions are:
- IDLE to LEAD, when an enable is set at a launch.
- LEAD to LEFT, always after one bit.
- LEFT to RIGHT, after slot bit 31.
- RIGHT to LEFT, after slot bit 31 when a direction is active.
- RIGHT to IDLE, after slot bit 31 when no direction is active.

Top module: `i2s_frame_ser`

## Requirements
- R1: While reset is held and until the first launch, `idle`=1, `sdo`=0, all strobes are 0, the raw bit clock is 0 and raw word-select is 1. The pins carry these values XOR the polarity controls.
- R2: The raw bit clock toggles on every clock in which `half_tick`=1 and holds otherwise. A 1-to-0 transition is a launch, where the sequencer advances and `sdo` changes. A 0-to-1 transition is a capture, where `sdi` is sampled.
- R3: Raw word-select is 0 during LEAD, during left slot bits 0..30 and during right slot bit 31. It is 1 during left slot bit 31, during right slot bits 0..30 and during IDLE. The left channel therefore starts one bit after word-select falls.
- R4: In each slot, `sdo` carries the fetched 16-bit word MSB-first on slot bits 0..15 and 0 on slot bits 16..31. It is 0 in IDLE and LEAD.
- R5: At the launch that enters slot bit 0, with transmit active and `tx_valid`=1, the block takes `tx_data` and raises `tx_pop` for that one clock.
- R6: At the same point with `tx_valid`=0, there is no pop. `tx_urun` pulses for one clock and the slot is sent as all zeros.
- R7: With receive active, the `sdi` values captured on slot bits 0..15 form a word, first bit in bit 15. Slot bits 16..31 are ignored. The word appears on `rx_data` with `rx_push`=1 in the clock after the capture of slot bit 15, provided `rx_ready`=1.
- R8: If `rx_ready`=0 in that clock, the word is dropped, `rx_push` stays 0 and `rx_orun` pulses.
- R9: `tx_en` and `rx_en` are sampled only at the launch that enters right slot bit 31, or at a launch in IDLE. A running frame always completes. If both sampled enables are 0, the block returns to IDLE and `idle`=1 after that frame.
- R10: `sck_o` equals the raw bit clock XOR `bclk_inv`, and `ws_o` equals raw word-select XOR `ws_inv`. The two controls act independently.
- R11: Leaving IDLE inserts exactly one LEAD bit before the left slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| half_tick | input | 1 | Half-bit-period strobe from the divider |
| tx_en | input | 1 | Transmit enable |
| rx_en | input | 1 | Receive enable |
| bclk_inv | input | 1 | Bit-clock pin inversion |
| ws_inv | input | 1 | Word-select pin inversion |
| sck_o | output | 1 | Bit clock pin |
| ws_o | output | 1 | Word-select pin |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |
| tx_data | input | DATA_W | Head of transmit FIFO |
| tx_valid | input | 1 | Transmit FIFO not empty |
| tx_pop | output | 1 | Transmit FIFO pop |
| tx_urun | output | 1 | Transmit underrun strobe |
| rx_data | output | DATA_W | Received sample |
| rx_push | output | 1 | Receive FIFO push |
| rx_ready | input | 1 | Receive FIFO not full |
| rx_orun | output | 1 | Receive overrun strobe |
| idle | output | 1 | No frame in progress |

## Verification
Two events share a single launch edge. The frame sequencer samples the enables at the same edge that drives word-select low for the last bit of the right slot. The bench moves `rx_en` on a sweep of clock offsets around that edge, at two half-ticks per bit. It compares every cycle against a behavioural frame-position model, which decides from the enable value present at that edge whether the next frame captures data. A wrong sampling point then shows up as missing or extra `rx_push` pulses, or as a late `idle`.

// File: rtl/i2s_ser_pkg.sv
package i2s_ser_pkg;
    typedef enum logic [1:0] {
        FS_IDLE  = 2'd0,
        FS_LEAD  = 2'd1,
        FS_LEFT  = 2'd2,
        FS_RIGHT = 2'd3
    } fsm_state_t;
endpackage

// File: rtl/i2s_frame_fsm.sv
module i2s_frame_fsm
    import i2s_ser_pkg::*;
#(
    parameter int SLOT_W = 32,
    parameter int CNT_W  = $clog2(SLOT_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             half_tick,
    input  logic             tx_en,
    input  logic             rx_en,
    output fsm_state_t       state,
    output logic [CNT_W-1:0] bcnt,
    output logic             sck_raw,
    output logic             ws_raw,
    output logic             launch,
    output logic             capture,
    output logic             slot_start,
    output logic             tx_act,
    output logic             rx_act
);
    localparam logic [CNT_W-1:0] LAST  = CNT_W'(SLOT_W - 1);
    localparam logic [CNT_W-1:0] PRELD = CNT_W'(SLOT_W - 2);

    fsm_state_t       nxt_state;
    logic [CNT_W-1:0] nxt_cnt;
    logic             load_act;

    assign launch  = half_tick & sck_raw;
    assign capture = half_tick & ~sck_raw;

    // next-state decode
    always_comb begin
        nxt_state = state;
        nxt_cnt   = bcnt;
        load_act  = 1'b0;
        unique case (state)
            FS_IDLE: begin
                if (tx_en | rx_en) begin
                    nxt_state = FS_LEAD;
                    load_act  = 1'b1;
                end
            end
            FS_LEAD: begin
                nxt_state = FS_LEFT;
                nxt_cnt   = '0;
            end
            FS_LEFT: begin
                if (bcnt == LAST) begin
                    nxt_state = FS_RIGHT;
                    nxt_cnt   = '0;
                end else begin
                    nxt_cnt = bcnt + 1'b1;
                end
            end
            FS_RIGHT: begin
                if (bcnt == LAST) begin
                    nxt_state = (tx_act | rx_act) ? FS_LEFT : FS_IDLE;
                    nxt_cnt   = '0;
                end else begin
                    nxt_cnt = bcnt + 1'b1;
                    if (bcnt == PRELD) load_act = 1'b1;
                end
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= FS_IDLE;
            bcnt    <= '0;
            sck_raw <= 1'b0;
            tx_act  <= 1'b0;
            rx_act  <= 1'b0;
        end else begin
            if (half_tick) sck_raw <= ~sck_raw;
            if (launch) begin
                state <= nxt_state;
                bcnt  <= nxt_cnt;
                if (load_act) begin
                    tx_act <= tx_en;
                    rx_act <= rx_en;
                end
            end
        end
    end

    // outputs
    always_comb begin
        slot_start = launch && (nxt_state == FS_LEFT || nxt_state == FS_RIGHT)
                     && (nxt_cnt == '0);
        ws_raw = 1'b1;
        unique case (state)
            FS_IDLE:  ws_raw = 1'b1;
            FS_LEAD:  ws_raw = 1'b0;
            FS_LEFT:  ws_raw = (bcnt == LAST);
            FS_RIGHT: ws_raw = (bcnt != LAST);
        endcase
    end
endmodule

// File: rtl/i2s_tx_shift.sv
module i2s_tx_shift #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic              slot_start,
    input  logic              tx_act,
    input  logic              tx_valid,
    input  logic [DATA_W-1:0] tx_data,
    output logic              sdo,
    output logic              tx_pop,
    output logic              tx_urun
);
    logic              fetch;
    logic [DATA_W-1:0] word;
    logic [DATA_W-1:0] sh;

    assign fetch   = slot_start & tx_act;
    assign tx_pop  = fetch & tx_valid;
    assign tx_urun = fetch & ~tx_valid;
    assign word    = tx_pop ? tx_data : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sdo <= 1'b0;
            sh  <= '0;
        end else if (slot_start) begin
            sdo <= word[DATA_W-1];
            sh  <= {word[DATA_W-2:0], 1'b0};
        end else if (launch) begin
            sdo <= sh[DATA_W-1];
            sh  <= {sh[DATA_W-2:0], 1'b0};
        end
    end
endmodule

// File: rtl/i2s_rx_shift.sv
module i2s_rx_shift
    import i2s_ser_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  fsm_state_t        state,
    input  logic [CNT_W-1:0]  bcnt,
    input  logic              rx_act,
    input  logic              sdi,
    input  logic              rx_ready,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_push,
    output logic              rx_orun
);
    localparam logic [CNT_W-1:0] DLAST = CNT_W'(DATA_W - 1);

    logic              in_data;
    logic              last_bit;
    logic              pend;
    logic [DATA_W-1:0] sh;

    assign in_data  = rx_act && (state == FS_LEFT || state == FS_RIGHT) && (bcnt <= DLAST);
    assign last_bit = in_data && (bcnt == DLAST);
    assign rx_push  = pend & rx_ready;
    assign rx_orun  = pend & ~rx_ready;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh      <= '0;
            rx_data <= '0;
            pend    <= 1'b0;
        end else begin
            pend <= capture & last_bit;
            if (capture && in_data) sh <= {sh[DATA_W-2:0], sdi};
            if (capture && last_bit) rx_data <= {sh[DATA_W-2:0], sdi};
        end
    end
endmodule

// File: rtl/i2s_frame_ser.sv
module i2s_frame_ser
    import i2s_ser_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int SLOT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              half_tick,
    input  logic              tx_en,
    input  logic              rx_en,
    input  logic              bclk_inv,
    input  logic              ws_inv,
    output logic              sck_o,
    output logic              ws_o,
    output logic              sdo,
    input  logic              sdi,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_pop,
    output logic              tx_urun,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_push,
    input  logic              rx_ready,
    output logic              rx_orun,
    output logic              idle
);
    localparam int CNT_W = $clog2(SLOT_W);

    fsm_state_t       state;
    logic [CNT_W-1:0] bcnt;
    logic             sck_raw, ws_raw, launch, capture, slot_start, tx_act, rx_act;

    i2s_frame_fsm #(.SLOT_W(SLOT_W), .CNT_W(CNT_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .half_tick(half_tick),
        .tx_en(tx_en), .rx_en(rx_en),
        .state(state), .bcnt(bcnt), .sck_raw(sck_raw), .ws_raw(ws_raw),
        .launch(launch), .capture(capture), .slot_start(slot_start),
        .tx_act(tx_act), .rx_act(rx_act)
    );

    i2s_tx_shift #(.DATA_W(DATA_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .launch(launch), .slot_start(slot_start),
        .tx_act(tx_act), .tx_valid(tx_valid), .tx_data(tx_data),
        .sdo(sdo), .tx_pop(tx_pop), .tx_urun(tx_urun)
    );

    i2s_rx_shift #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .capture(capture), .state(state), .bcnt(bcnt),
        .rx_act(rx_act), .sdi(sdi), .rx_ready(rx_ready),
        .rx_data(rx_data), .rx_push(rx_push), .rx_orun(rx_orun)
    );

    assign sck_o = sck_raw ^ bclk_inv;
    assign ws_o  = ws_raw ^ ws_inv;
    assign idle  = (state == FS_IDLE);
endmodule

// File: rtl/i2s_frame_ser_chk.sv
module i2s_frame_ser_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              half_tick,
    input logic              bclk_inv,
    input logic              sck_o,
    input logic              sdo,
    input logic              tx_valid,
    input logic              tx_pop,
    input logic              tx_urun,
    input logic [DATA_W-1:0] rx_data,
    input logic              rx_push,
    input logic              rx_ready,
    input logic              rx_orun,
    input logic              idle
);
    assert_sck_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(half_tick) && $stable(bclk_inv)) |-> $stable(sck_o));

    assert_pop_needs_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |-> tx_valid);

    assert_pop_urun_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_pop && tx_urun));

    assert_push_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |=> !rx_push);

    assert_push_needs_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |-> rx_ready);

    assert_orun_when_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_orun |-> (!rx_ready && !rx_push));

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> (!sdo && !tx_pop && !tx_urun));
endmodule

bind i2s_frame_ser i2s_frame_ser_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .half_tick(half_tick), .bclk_inv(bclk_inv),
    .sck_o(sck_o), .sdo(sdo), .tx_valid(tx_valid), .tx_pop(tx_pop),
    .tx_urun(tx_urun), .rx_data(rx_data), .rx_push(rx_push),
    .rx_ready(rx_ready), .rx_orun(rx_orun), .idle(idle)
);

// File: tb/tb_i2s_frame_ser.sv
module tb_i2s_frame_ser;
    localparam int DW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic half_tick = 1'b0;
    logic tx_en = 1'b0, rx_en = 1'b0, bclk_inv = 1'b0, ws_inv = 1'b0;
    logic sck_o, ws_o, sdo, sdi = 1'b0;
    logic [DW-1:0] tx_data = '0;
    logic tx_valid = 1'b0, tx_pop, tx_urun;
    logic [DW-1:0] rx_data;
    logic rx_push, rx_ready = 1'b1, rx_orun, idle;

    always #10 clk = ~clk;

    i2s_frame_ser dut (
        .clk(clk), .rst_n(rst_n), .half_tick(half_tick), .tx_en(tx_en), .rx_en(rx_en),
        .bclk_inv(bclk_inv), .ws_inv(ws_inv), .sck_o(sck_o), .ws_o(ws_o), .sdo(sdo),
        .sdi(sdi), .tx_data(tx_data), .tx_valid(tx_valid), .tx_pop(tx_pop),
        .tx_urun(tx_urun), .rx_data(rx_data), .rx_push(rx_push), .rx_ready(rx_ready),
        .rx_orun(rx_orun), .idle(idle)
    );

    int total = 0, bad = 0;
    int cyc = 0;
    int gap = 1;
    bit refill = 1'b1;
    int rdy_mode = 0;
    logic [15:0] next_tx = 16'h8001;

    logic [15:0] txq[$];
    int m_pos = -2;
    bit m_sck = 0, m_txa = 0, m_rxa = 0, m_pend = 0;
    logic [15:0] m_txw[2];
    logic [15:0] m_pw[2];
    logic [15:0] m_acc = '0, m_rxw = '0;
    logic [15:0] pseed = 16'hACE1;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit exp_ws(int p);
        if (p == -2) return 1'b1;
        if (p == -1) return 1'b0;
        return (p >= 31 && p <= 62);
    endfunction

    function automatic bit exp_sdo(int p);
        if (p < 0) return 1'b0;
        if ((p % 32) >= 16) return 1'b0;
        return m_txw[p / 32][15 - (p % 32)];
    endfunction

    // drive, compare and model
    initial begin
        m_txw[0] = '0; m_txw[1] = '0; m_pw[0] = '0; m_pw[1] = '0;
        forever begin
            @(negedge clk);
            cyc++;
            if (refill && txq.size() < 4) begin
                txq.push_back(next_tx);
                next_tx = next_tx * 16'd5 + 16'h3C27;
            end
            half_tick = ((cyc % gap) == 0);
            tx_valid  = (txq.size() > 0);
            tx_data   = (txq.size() > 0) ? txq[0] : '0;
            if (m_pos >= 0 && (m_pos % 32) < 16) sdi = m_pw[m_pos / 32][15 - (m_pos % 32)];
            else sdi = (m_pos[1] ^ cyc[0]);
            rx_ready = (rdy_mode == 0) ? 1'b1 : (rdy_mode == 2) ? 1'b0 : (((cyc / 7) % 2) == 0);
            #2;
            if (!rst_n) begin
                // R1: reset values at the ports
                chk("R1 idle", idle, 1);
                chk("R1 sdo", sdo, 0);
                chk("R1 sck_o", sck_o, bclk_inv);
                chk("R1 ws_o", ws_o, 1'b1 ^ ws_inv);
                chk("R1 strobes", {tx_pop, tx_urun, rx_push, rx_orun}, 0);
                m_pos = -2; m_sck = 0; m_txa = 0; m_rxa = 0; m_pend = 0; m_acc = '0;
                m_txw[0] = '0; m_txw[1] = '0;
            end else begin
                int np;
                bit launch_e, fetch_e, exp_pop, exp_urun, ldact;
                launch_e = half_tick && m_sck;
                np = m_pos;
                ldact = 0;
                if (launch_e) begin
                    if (m_pos == -2) begin
                        if (tx_en || rx_en) begin np = -1; ldact = 1; end
                    end else if (m_pos == -1) np = 0;
                    else if (m_pos == 63) np = (m_txa || m_rxa) ? 0 : -2;
                    else begin np = m_pos + 1; if (np == 63) ldact = 1; end
                end
                fetch_e  = launch_e && (np == 0 || np == 32) && np != m_pos;
                exp_pop  = fetch_e && m_txa && (txq.size() > 0);
                exp_urun = fetch_e && m_txa && (txq.size() == 0);
                // compare current cycle
                chk(bclk_inv ? "R10 sck_o" : "R2 sck_o", sck_o, m_sck ^ bclk_inv);
                chk(ws_inv ? "R10 ws_o" : (m_pos == -1 ? "R11 ws_o" : "R3 ws_o"),
                    ws_o, exp_ws(m_pos) ^ ws_inv);
                chk("R4 sdo", sdo, exp_sdo(m_pos));
                chk("R9 idle", idle, m_pos == -2);
                chk("R5 tx_pop", tx_pop, exp_pop);
                chk("R6 tx_urun", tx_urun, exp_urun);
                chk("R7 rx_push", rx_push, m_pend && rx_ready);
                chk("R8 rx_orun", rx_orun, m_pend && !rx_ready);
                if (m_pend && rx_ready) chk("R7 rx_data", rx_data, m_rxw);
                // advance to the coming edge
                m_pend = 0;
                if (half_tick && !m_sck) begin
                    if (m_rxa && m_pos >= 0 && (m_pos % 32) < 16) begin
                        m_acc = {m_acc[14:0], sdi};
                        if ((m_pos % 32) == 15) begin m_pend = 1; m_rxw = m_acc; end
                    end
                end
                if (launch_e) begin
                    if (ldact) begin m_txa = tx_en; m_rxa = rx_en; end
                    if (fetch_e) begin
                        m_txw[np / 32] = exp_pop ? txq[0] : 16'h0000;
                        m_pw[np / 32]  = pseed;
                        pseed = {pseed[14:0], pseed[15] ^ pseed[13] ^ pseed[12] ^ pseed[10]};
                    end
                    if (exp_pop) void'(txq.pop_front());
                    m_pos = np;
                end
                if (half_tick) m_sck = !m_sck;
            end
        end
    end

    task automatic wait_cyc(int n);
        repeat (n) @(posedge clk);
        #3;
    endtask

    task automatic run_all();
        wait_cyc(6);
        rst_n = 1'b1;
        wait_cyc(30);                               // R1/R9: stays idle
        tx_en = 1; rx_en = 1; gap = 1;              // R3 R4 R5 R7 R11
        wait_cyc(800);
        gap = 2; bclk_inv = 1;                      // R10 bit clock
        wait_cyc(1100);
        gap = 3; bclk_inv = 0; ws_inv = 1;          // R10 word select
        wait_cyc(1200);
        ws_inv = 0; gap = 1;
        refill = 0;                                 // R6 underrun
        wait_cyc(500);
        refill = 1;
        rdy_mode = 2;                               // R8 overrun
        wait_cyc(300);
        rdy_mode = 1;
        wait_cyc(500);
        rdy_mode = 0;
        tx_en = 0;                                  // rx only
        wait_cyc(300);
        rx_en = 0;                                  // R9 drain to idle
        wait_cyc(300);
        tx_en = 1;                                  // tx only, R11 lead
        wait_cyc(400);
        rx_en = 1; gap = 2;
        // sweep rx_en changes around the enable sampling edge (R9)
        for (int d = 250; d <= 258; d++) begin
            @(negedge ws_o);
            repeat (d) @(posedge clk);
            #3 rx_en = ~rx_en;
        end
        wait_cyc(600);
        for (int k = 0; k < 8; k++) begin
            wait_cyc(90 + k * 37);
            tx_en = ~tx_en;
        end
        tx_en = 0; rx_en = 0;
        wait_cyc(700);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                bad++;
                $display("FAIL watchdog R9 actual=running expected=finished");
            end
        join_any
        disable fork;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule